// File: doc/BRIEF.md
# Fieldbus Frame Receiver with Held Result Bank

The block watches the receive line of a Manchester-coded fieldbus, one half-bit at a time. While idle it hunts for the frame start sequence. Once that sequence is found it reports the find, then decodes the frame body in 16-half-bit groups. The first decoded byte becomes the control byte. The payload bytes that follow are packed into a bank of 32-bit words. When the end sequence arrives it checks the CRC and reports either a good frame or a CRC fault. The contents of the payload are never interpreted: only the start sequence, the end sequence and the CRC are validated.

Results are double-buffered. Bytes decode into a working bank. Only a good frame copies that bank, the control byte and the fill counts into the held copy. The host therefore reads a stable result until the next good frame or a receive reset. Half-bits enter as a valid-qualified stream with no ready signal. The line cannot be stalled, so the block accepts every half-bit that has `half_vld_i` set, and gaps between strobes are allowed.

Top module: `fbr_frame_rx`

## Requirements
- R1: While hunting, the block compares the 32 most recent half-bits with the start pattern 32'hAAAA_B24D, oldest half in the most significant bit. On a match, `fss_det_o` is high for exactly the one cycle after the clock edge that took the last half-bit, and body decoding begins.
- R2: Body half-bits are taken in pairs. The pair (1,0) is bit 1 and (0,1) is bit 0. Eight pairs form a byte, most significant bit first. The 16-half group 16'hB326 is the end sequence.
- R3: The first body byte is the control byte. Payload byte k goes to word k/4, lane k%4, and lane 0 is bits 7:0. Lanes that a frame does not fill read as zero. Any byte value is accepted.
- R4: At the end sequence exactly one of `frame_ok_o` or `crc_err_o` pulses for one cycle. The frame is good when it holds at least three bytes and the CRC-16 (polynomial 0x1DCF, preset 16'hFFFF, most significant bit first) over all body bytes leaves the fixed residue. The transmitter appends the complemented CRC, high byte first.
- R5: The last two body bytes are the CRC and are not stored. `words_o` is ceil(n/4) and `last_bytes_o` is n%4, where a zero remainder reads as 4 and an empty payload gives 0 for both. Here n is the number of payload bytes.
- R6: The control byte, the counts and the bank change only on a good frame or a receive reset. A CRC fault leaves them untouched.
- R7: If a frame tries to store more than 268 payload bytes, it is dropped without any result pulse and hunting resumes.
- R8: An invalid pair, (1,1) or (0,0), in a body byte group that is not the end sequence drops the frame without a result pulse.
- R9: `rst_n` (asynchronous) and `rx_rst_i` (synchronous) clear the held results to zero and return the block to hunting. `rx_rst_i` takes priority over a frame ending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_rst_i | input | 1 | Synchronous receive reset |
| half_vld_i | input | 1 | Half-bit strobe (stream valid, no ready) |
| half_i | input | 1 | Sampled line half-bit |
| fss_det_o | output | 1 | Start sequence found, one-cycle pulse |
| frame_ok_o | output | 1 | Good frame, one-cycle pulse |
| crc_err_o | output | 1 | CRC fault, one-cycle pulse |
| ctrl_o | output | 8 | Held control byte |
| words_o | output | 7 | Held count of filled payload words |
| last_bytes_o | output | 3 | Held count of valid bytes in the last word |
| rd_idx_i | input | 7 | Held bank word select |
| rd_word_o | output | 32 | Selected held payload word |

## Verification
Completing a frame and a receive reset can fall in the same cycle. The bench raises `rx_rst_i` in the very cycle that delivers the last half-bit of a well-formed frame's end sequence. It then expects no result pulse and a held state cleared to zero. The reference model compares every output on every clock. A later good frame shows that hunting resumed cleanly after the collision.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam logic [31:0] FSS_PAT  = 32'hAAAA_B24D;
  localparam logic [15:0] FES_PAT  = 16'hB326;
  localparam logic [15:0] CRC_POLY = 16'h1DCF;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] s, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = s;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  // Register value left after a frame carrying its own complemented CRC:
  // independent of the data, equal to sixteen ones fed into a cleared register.
  function automatic logic [15:0] crc16_residue();
    logic [15:0] r;
    r = crc16_step(16'h0000, 8'hFF);
    r = crc16_step(r, 8'hFF);
    return r;
  endfunction
endpackage

// File: rtl/fbr_half_shift.sv
module fbr_half_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic         half,
  output logic [W-1:0] sreg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sreg_o <= '0;
    else if (clr) sreg_o <= '0;
    else if (stb) sreg_o <= {sreg_o[W-2:0], half};
  end
endmodule

// File: rtl/fbr_sym_decode.sv
module fbr_sym_decode
  import fbr_pkg::*;
(
  input  logic [15:0] grp,
  output logic [7:0]  byte_o,
  output logic        viol_o,
  output logic        end_o
);
  logic [7:0] bad;

  for (genvar i = 0; i < 8; i++) begin : g_pair
    assign byte_o[7-i] = grp[15-2*i];
    assign bad[i]      = (grp[15-2*i] == grp[14-2*i]);
  end

  assign viol_o = |bad;
  assign end_o  = (grp == FES_PAT);
endmodule

// File: rtl/fbr_crc16.sv
module fbr_crc16
  import fbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_o <= CRC_INIT;
    else if (init) crc_o <= CRC_INIT;
    else if (en)   crc_o <= crc16_step(crc_o, din);
  end
endmodule

// File: rtl/fbr_word_bank.sv
module fbr_word_bank #(
  parameter int NWORDS = 67,
  parameter int BC_W   = 9,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_work,
  input  logic             wr_en,
  input  logic [BC_W-1:0]  wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic             clr_held,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [31:0] work_q [NWORDS];
  logic [31:0] held_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_q[g] <= '0;
        held_q[g] <= '0;
      end else begin
        if (clr_work)
          work_q[g] <= '0;
        else if (wr_en && (int'(wr_idx[BC_W-1:2]) == g))
          work_q[g][8*wr_idx[1:0] +: 8] <= wr_byte;
        if (clr_held)    held_q[g] <= '0;
        else if (commit) held_q[g] <= work_q[g];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NWORDS; i++)
      if (int'(rd_idx) == i) rd_word = held_q[i];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NWORDS*4)); // R7
endmodule

// File: rtl/fbr_frame_rx.sv
module fbr_frame_rx
  import fbr_pkg::*;
#(
  parameter int NWORDS = 67,
  localparam int IDX_W = $clog2(NWORDS+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_rst_i,
  input  logic             half_vld_i,
  input  logic             half_i,
  output logic             fss_det_o,
  output logic             frame_ok_o,
  output logic             crc_err_o,
  output logic [7:0]       ctrl_o,
  output logic [IDX_W-1:0] words_o,
  output logic [2:0]       last_bytes_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_word_o
);
  localparam int MAX_BYTES = NWORDS * 4;
  localparam int BC_W      = $clog2(MAX_BYTES + 1);
  localparam logic [15:0] RESIDUE = crc16_residue();

  rx_state_e       state;
  logic [3:0]      half_cnt;
  logic [7:0]      pend0, pend1, work_ctrl;
  logic [1:0]      pend_cnt;
  logic            got_ctrl;
  logic [BC_W-1:0] pay_cnt;
  logic [31:0]     sreg;
  logic [15:0]     crc;
  logic [7:0]      dec_byte;
  logic            dec_viol, dec_end;

  logic fss_hit, grp_done, commit_byte, overflow, pay_wr, good, leave, byte_ok;
  logic [BC_W:0]   words_full;

  assign fss_hit     = half_vld_i && (state == ST_HUNT) && ({sreg[30:0], half_i} == FSS_PAT);
  assign grp_done    = half_vld_i && (state == ST_BODY) && (half_cnt == 4'd15);
  assign byte_ok     = grp_done && !dec_end && !dec_viol;
  assign commit_byte = byte_ok && (pend_cnt == 2'd2);
  assign overflow    = commit_byte && got_ctrl && (int'(pay_cnt) == MAX_BYTES);
  assign pay_wr      = commit_byte && got_ctrl && !overflow;
  assign good        = grp_done && dec_end && (crc == RESIDUE) && (pend_cnt == 2'd2) && got_ctrl;
  assign leave       = grp_done && (dec_end || dec_viol || overflow);
  assign words_full  = ({1'b0, pay_cnt} + (BC_W+1)'(3)) >> 2;

  fbr_half_shift #(.W(32)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst_i || leave), .stb(half_vld_i),
    .half(half_i), .sreg_o(sreg));

  fbr_sym_decode u_dec (
    .grp({sreg[14:0], half_i}), .byte_o(dec_byte), .viol_o(dec_viol), .end_o(dec_end));

  fbr_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(fss_hit), .en(byte_ok), .din(dec_byte), .crc_o(crc));

  fbr_word_bank #(.NWORDS(NWORDS), .BC_W(BC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_work(fss_hit), .wr_en(pay_wr && !rx_rst_i),
    .wr_idx(pay_cnt), .wr_byte(pend0), .commit(good && !rx_rst_i),
    .clr_held(rx_rst_i), .rd_idx(rd_idx_i), .rd_word(rd_word_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_HUNT;
      half_cnt     <= '0;
      pend0        <= '0;
      pend1        <= '0;
      pend_cnt     <= '0;
      got_ctrl     <= 1'b0;
      work_ctrl    <= '0;
      pay_cnt      <= '0;
      fss_det_o    <= 1'b0;
      frame_ok_o   <= 1'b0;
      crc_err_o    <= 1'b0;
      ctrl_o       <= '0;
      words_o      <= '0;
      last_bytes_o <= '0;
    end else if (rx_rst_i) begin
      state        <= ST_HUNT;
      fss_det_o    <= 1'b0;
      frame_ok_o   <= 1'b0;
      crc_err_o    <= 1'b0;
      ctrl_o       <= '0;
      words_o      <= '0;
      last_bytes_o <= '0;
    end else begin
      fss_det_o  <= fss_hit;
      frame_ok_o <= 1'b0;
      crc_err_o  <= 1'b0;
      if (fss_hit) begin
        state    <= ST_BODY;
        half_cnt <= '0;
        pend_cnt <= '0;
        got_ctrl <= 1'b0;
        pay_cnt  <= '0;
      end else if (state == ST_BODY && half_vld_i) begin
        half_cnt <= half_cnt + 4'd1;
      end
      if (grp_done) begin
        if (dec_end) begin
          state      <= ST_HUNT;
          frame_ok_o <= good;
          crc_err_o  <= !good;
          if (good) begin
            ctrl_o       <= work_ctrl;
            words_o      <= IDX_W'(words_full);
            last_bytes_o <= (pay_cnt == '0)      ? 3'd0 :
                            (pay_cnt[1:0] == 2'd0) ? 3'd4 : {1'b0, pay_cnt[1:0]};
          end
        end else if (dec_viol || overflow) begin
          state <= ST_HUNT;
        end else begin
          pend1 <= dec_byte;
          pend0 <= pend1;
          if (pend_cnt != 2'd2) pend_cnt <= pend_cnt + 2'd1;
          if (commit_byte) begin
            if (!got_ctrl) begin
              work_ctrl <= pend0;
              got_ctrl  <= 1'b1;
            end else begin
              pay_cnt <= pay_cnt + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok_o && crc_err_o)); // R4
  AST_FSS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fss_det_o |=> !fss_det_o); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok_o && !$past(rx_rst_i)) |-> ($stable(words_o) && $stable(ctrl_o) && $stable(last_bytes_o))); // R6
  AST_LAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bytes_o <= 3'd4) && ((words_o == '0) == (last_bytes_o == 3'd0))); // R5
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_i |=> (!frame_ok_o && words_o == '0 && ctrl_o == 8'd0)); // R9
endmodule

// File: tb/test_fbr_frame_rx.sv
module test_fbr_frame_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_rst_i = 1'b0, half_vld_i = 1'b0, half_i = 1'b0;
  logic fss_det_o, frame_ok_o, crc_err_o;
  logic [7:0] ctrl_o;
  logic [6:0] words_o, rd_idx_i = '0;
  logic [2:0] last_bytes_o;
  logic [31:0] rd_word_o;

  always #5 clk = ~clk;

  fbr_frame_rx i_fbr_frame_rx (.*);

  int checks = 0, errs = 0;
  bit mon_en = 1'b0;
  logic exp_fss = 0, exp_ok = 0, exp_err = 0;
  logic [7:0]  m_ctrl = 0;
  logic [6:0]  m_words = 0;
  logic [2:0]  m_last = 0;
  logic [31:0] m_bank [67];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (mon_en) begin
      chk(fss_det_o === exp_fss, "R1 start pulse", 32'(fss_det_o), 32'(exp_fss));
      chk(frame_ok_o === exp_ok, "R4 frame ok pulse", 32'(frame_ok_o), 32'(exp_ok));
      chk(crc_err_o === exp_err, "R4 crc error pulse", 32'(crc_err_o), 32'(exp_err));
      chk({ctrl_o, words_o, last_bytes_o} === {m_ctrl, m_words, m_last}, "R6 held results",
          32'({ctrl_o, words_o, last_bytes_o}), 32'({m_ctrl, m_words, m_last}));
    end
  end

  function automatic logic [15:0] ref_crc(input logic [7:0] d[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (d[k])
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[k][b];
        c = {c[14:0], 1'b0};
        if (fb) c ^= 16'h1DCF;
      end
    return c;
  endfunction

  task automatic check_bank(input string req);
    for (int w = 0; w < 67; w++) begin
      rd_idx_i = 7'(w);
      #1;
      chk(rd_word_o === m_bank[w], req, rd_word_o, m_bank[w]);
    end
  endtask

  // kind: 0 good, 1 corrupted CRC, 2 bad symbol, 4 receive reset on last half
  task automatic run_frame(input logic [7:0] c, input int npay, input int kind);
    logic [7:0] by[$];
    bit hq[$];
    logic [15:0] crc, pat;
    int fss_i, end_i;
    bit abort, ok, er;
    by.push_back(c);
    for (int i = 0; i < npay; i++) by.push_back(8'((i * 29 + c + 7) % 256));
    crc = ref_crc(by);
    by.push_back(~crc[15:8]);
    by.push_back(~crc[7:0]);
    if (kind == 1) by[0] = by[0] ^ 8'h10;
    for (int i = 0; i < 6; i++) hq.push_back(1'b0);
    for (int i = 31; i >= 0; i--) hq.push_back(32'hAAAA_B24D >> i);
    fss_i = hq.size() - 1;
    foreach (by[j])
      for (int b = 7; b >= 0; b--) begin
        if (kind == 2 && j == 1 && b == 5) begin
          hq.push_back(1'b1); hq.push_back(1'b1);
        end else begin
          hq.push_back(by[j][b]); hq.push_back(!by[j][b]);
        end
      end
    pat = 16'hB326;
    for (int i = 15; i >= 0; i--) hq.push_back(pat[i]);
    end_i = hq.size() - 1;
    for (int i = 0; i < 4; i++) hq.push_back(1'b0);
    abort = (kind == 2) || (npay > 268);
    ok = !abort && kind == 0;
    er = !abort && kind == 1;
    foreach (hq[i]) begin
      @(negedge clk);
      half_vld_i = 1'b1;
      half_i = hq[i];
      exp_fss = (i == fss_i);
      if (i == end_i) begin
        exp_ok = ok;
        exp_err = er;
        if (kind == 4) begin
          rx_rst_i = 1'b1;
          m_ctrl = 0; m_words = 0; m_last = 0;
          foreach (m_bank[w]) m_bank[w] = 0;
        end
        if (ok) begin
          m_ctrl = c;
          m_words = 7'((npay + 3) / 4);
          m_last = (npay == 0) ? 3'd0 : ((npay % 4 == 0) ? 3'd4 : 3'(npay % 4));
          foreach (m_bank[w]) m_bank[w] = 0;
          for (int k = 0; k < npay; k++) m_bank[k/4][8*(k%4) +: 8] = by[k+1];
        end
      end
      @(negedge clk);
      half_vld_i = 1'b0;
      rx_rst_i = 1'b0;
      exp_fss = 0; exp_ok = 0; exp_err = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    foreach (m_bank[w]) m_bank[w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({fss_det_o, frame_ok_o, crc_err_o, ctrl_o, words_o, last_bytes_o} === '0,
        "R9 reset state", 32'({ctrl_o, words_o, last_bytes_o}), 0);
    mon_en = 1'b1;
    check_bank("R9 reset bank");
    run_frame(8'h03, 5, 0);   check_bank("R3 five byte packing");      // R5: 2 words, 1 byte
    run_frame(8'hFF, 0, 0);   check_bank("R5 empty payload");
    run_frame(8'h5A, 8, 0);   check_bank("R3 full last word");
    run_frame(8'h21, 6, 1);   check_bank("R6 crc fault keeps bank");   // R4 crc error
    run_frame(8'h44, 9, 2);   check_bank("R8 bad symbol dropped");
    run_frame(8'h80, 268, 0); check_bank("R7 largest frame kept");
    run_frame(8'h81, 269, 0); check_bank("R7 oversize dropped");
    run_frame(8'h12, 7, 4);   check_bank("R9 reset wins over frame end");
    run_frame(8'h00, 3, 0);   check_bank("R2 decode after reset");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule